// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block keeps the running position of one DMA channel. Each time the data path reports that an element has been moved, the sequencer advances the current address by the signed X stride and counts down the elements left in the row. At the end of a row it either moves on to the next row, finishes the work, or asks for the next descriptor. The memory transfers and the descriptor fetches are done elsewhere.

In two-dimensional mode the row step does not start from the address one X stride past the last element. The final X step is dropped and the Y stride is added to the address of the last element of the row, so the Y stride is measured from that element. A row-interrupt pulse can be requested for every completed row. When the last row ends, stop flow ends the work and raises done; every other flow raises a one-cycle reload request. The channel then waits until the descriptor logic signals that it has loaded new programmed values.

The X stride must equal plus or minus the element size. A start or a reload that breaks this rule sets an error flag and leaves the channel halted.

Top module: `dma2d_seq`

## Requirements
- R1: A `start` pulse with a legal stride loads `cur_addr` from `start_addr`, `cur_x` from `x_count` and `cur_y` from `y_count`, sets `running` and clears `done` on the next clock edge. A programmed count of zero loads as 16'hFFFF. `start` takes priority over `elem_ok` in the same cycle.
- R2: While running and not waiting for a reload, each cycle with `elem_ok` high that is not the last element of a row adds `x_mod` to `cur_addr` and decrements `cur_x`. The modifiers `x_mod` and `y_mod` are 16-bit two's complement values, sign-extended to the address width, so a negative value lowers the address.
- R3: The element that brings `cur_x` from 1 to 0 ends a row. If `cfg_row_irq` is 1, `row_irq` is high for exactly the one cycle after that edge. If `cfg_row_irq` is 0, `row_irq` stays low.
- R4: At a row end with `cfg_2d` = 1 and `cur_y` > 1, the sequencer decrements `cur_y` and reloads `cur_x` from `x_count`. It sets `cur_addr` to the address of the row's last element plus `y_mod`.
- R5: At the end of the last row with `cfg_flow` = 2'b00 (stop), `cur_addr` advances by `x_mod`, `cur_x` becomes 0, `running` clears and `done` sets.
- R6: At the end of the last row with any other `cfg_flow` value, `reload_req` is high for one cycle, `running` stays 1 and the channel waits for a reload.
- R7: While the channel waits for a reload, `elem_ok` has no effect. `reload_done` reloads the address and counts from the programmed inputs, as a start does, and lets stepping resume.
- R8: While `running` is 0, `elem_ok` has no effect on `cur_addr` or `cur_x`.
- R9: The element size code `cfg_esz` means 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. Code 3 is reserved. A start or reload with a reserved size, or with `x_mod` not equal to plus or minus the element size, sets `cfg_err` and leaves the channel not running with its address and counts unchanged. A legal start clears `cfg_err`.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin work from the programmed values |
| reload_done | input | 1 | New programmed values are in place after a reload request |
| elem_ok | input | 1 | One element was accepted by the data path |
| cfg_2d | input | 1 | Two-dimensional mode |
| cfg_row_irq | input | 1 | Pulse `row_irq` at each row end |
| cfg_flow | input | 2 | 0 = stop at the end, other values = request reload |
| cfg_esz | input | 2 | Element size code |
| start_addr | input | 32 | Programmed start address |
| x_count | input | 16 | Programmed elements per row |
| x_mod | input | 16 | Signed X stride in bytes |
| y_count | input | 16 | Programmed row count |
| y_mod | input | 16 | Signed Y stride in bytes |
| cur_addr | output | 32 | Current address |
| cur_x | output | 16 | Elements left in the current row |
| cur_y | output | 16 | Rows left, including the current one |
| row_irq | output | 1 | One-cycle row-end interrupt |
| reload_req | output | 1 | One-cycle descriptor reload request |
| running | output | 1 | Channel is active |
| done | output | 1 | Work finished in stop flow |
| cfg_err | output | 1 | Unsupported stride or size at the last start or reload |

## Verification
The bench uses the default widths: a 32-bit address and 16-bit counts and modifiers. With these widths a zero count can be checked against its all-ones meaning. Because the modifiers are narrower than the address, the sign-extension path is exercised, including a negative Y stride that moves the address below the start of the work. The short counts in the table reach row ends, the last-row decision and all three stride sizes within a few cycles.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    typedef enum logic [1:0] {
        FLOW_STOP      = 2'd0,
        FLOW_REPEAT    = 2'd1,
        FLOW_LIST      = 2'd2,
        FLOW_LIST_WIDE = 2'd3
    } flow_e;

    typedef enum logic [1:0] {
        ESZ_BYTE = 2'd0,
        ESZ_HALF = 2'd1,
        ESZ_WORD = 2'd2,
        ESZ_RSVD = 2'd3
    } esz_e;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_WAIT = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic  two_d;
        logic  row_irq_en;
        flow_e flow;
        esz_e  esz;
    } ch_cfg_t;

    function automatic int elem_bytes(esz_e e);
        case (e)
            ESZ_BYTE: return 1;
            ESZ_HALF: return 2;
            ESZ_WORD: return 4;
            default:  return 0;
        endcase
    endfunction

    function automatic logic stride_legal(esz_e e, int m);
        int b;
        b = elem_bytes(e);
        if (b == 0) return 1'b0;
        return (m == b) || (m == -b);
    endfunction

endpackage

// File: rtl/dma2d_stride_chk.sv
module dma2d_stride_chk
    import dma2d_pkg::*;
#(
    parameter int MW = 16
) (
    input  esz_e            esz,
    input  logic [MW-1:0]   x_mod,
    output logic            legal
);
    logic signed [MW-1:0] mod_s;
    int                   mod_i;

    always_comb begin
        mod_s = x_mod;
        mod_i = int'(mod_s);
        legal = stride_legal(esz, mod_i);
    end

endmodule

// File: rtl/dma2d_step.sv
module dma2d_step #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int MW = 16
) (
    input  logic            two_d,
    input  logic [AW-1:0]   cur_addr,
    input  logic [CW-1:0]   cur_x,
    input  logic [CW-1:0]   cur_y,
    input  logic [CW-1:0]   x_reload,
    input  logic [MW-1:0]   x_mod,
    input  logic [MW-1:0]   y_mod,
    output logic [AW-1:0]   nxt_addr,
    output logic [CW-1:0]   nxt_x,
    output logic [CW-1:0]   nxt_y,
    output logic            row_end,
    output logic            last_elem
);
    logic [AW-1:0] xm_ext;
    logic [AW-1:0] ym_ext;
    logic [AW-1:0] addend;
    logic          more_rows;

    generate
        if (AW > MW) begin : g_ext
            assign xm_ext = {{(AW-MW){x_mod[MW-1]}}, x_mod};
            assign ym_ext = {{(AW-MW){y_mod[MW-1]}}, y_mod};
        end else if (AW == MW) begin : g_same
            assign xm_ext = x_mod;
            assign ym_ext = y_mod;
        end else begin : g_trunc
            assign xm_ext = x_mod[AW-1:0];
            assign ym_ext = y_mod[AW-1:0];
        end
    endgenerate

    always_comb begin
        row_end   = (cur_x == CW'(1));
        more_rows = two_d && (cur_y > CW'(1));
        last_elem = row_end && !more_rows;
        // The row jump replaces the final X step, so one adder serves both.
        addend    = (row_end && more_rows) ? ym_ext : xm_ext;
        nxt_addr  = cur_addr + addend;
        nxt_y     = cur_y;
        if (!row_end) begin
            nxt_x = cur_x - CW'(1);
        end else if (more_rows) begin
            nxt_x = x_reload;
            nxt_y = cur_y - CW'(1);
        end else begin
            nxt_x = '0;
        end
    end

endmodule

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
    import dma2d_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   reload_done,
    input  logic   elem_ok,
    input  logic   legal,
    input  flow_e  flow,
    input  logic   last_elem,
    output logic   accept,
    output logic   load,
    output logic   err_update,
    output logic   running,
    output logic   pending,
    output logic   done,
    output logic   reload_req
);
    ch_state_e st_q, st_d;
    logic      done_d, req_d;

    always_comb begin
        accept     = elem_ok && (st_q == CH_RUN) && !start;
        err_update = start || ((st_q == CH_WAIT) && reload_done);
        load       = err_update && legal;
        st_d       = st_q;
        done_d     = done;
        req_d      = 1'b0;
        if (start) begin
            st_d   = legal ? CH_RUN : CH_IDLE;
            done_d = 1'b0;
        end else begin
            case (st_q)
                CH_RUN: begin
                    if (accept && last_elem) begin
                        if (flow == FLOW_STOP) begin
                            st_d   = CH_IDLE;
                            done_d = 1'b1;
                        end else begin
                            st_d  = CH_WAIT;
                            req_d = 1'b1;
                        end
                    end
                end
                CH_WAIT: begin
                    if (reload_done) st_d = legal ? CH_RUN : CH_IDLE;
                end
                default: st_d = CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= CH_IDLE;
            done       <= 1'b0;
            reload_req <= 1'b0;
        end else begin
            st_q       <= st_d;
            done       <= done_d;
            reload_req <= req_d;
        end
    end

    assign running = (st_q != CH_IDLE);
    assign pending = (st_q == CH_WAIT);

    assert_reload_single_R6: assert property (@(posedge clk) disable iff (rst)
        reload_req |=> !reload_req);

    assert_reload_waits_R6: assert property (@(posedge clk) disable iff (rst)
        reload_req |-> (running && pending));

    assert_done_halts_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !running);

endmodule

// File: rtl/dma2d_seq.sv
module dma2d_seq
    import dma2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int MW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            reload_done,
    input  logic            elem_ok,
    input  logic            cfg_2d,
    input  logic            cfg_row_irq,
    input  logic [1:0]      cfg_flow,
    input  logic [1:0]      cfg_esz,
    input  logic [AW-1:0]   start_addr,
    input  logic [CW-1:0]   x_count,
    input  logic [MW-1:0]   x_mod,
    input  logic [CW-1:0]   y_count,
    input  logic [MW-1:0]   y_mod,
    output logic [AW-1:0]   cur_addr,
    output logic [CW-1:0]   cur_x,
    output logic [CW-1:0]   cur_y,
    output logic            row_irq,
    output logic            reload_req,
    output logic            running,
    output logic            done,
    output logic            cfg_err
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    ch_cfg_t       cfg;
    logic          legal, accept, load, err_update, pending;
    logic          row_end, last_elem;
    logic [AW-1:0] nxt_addr;
    logic [CW-1:0] nxt_x, nxt_y, x_eff, y_eff;

    always_comb begin
        cfg.two_d      = cfg_2d;
        cfg.row_irq_en = cfg_row_irq;
        cfg.flow       = flow_e'(cfg_flow);
        cfg.esz        = esz_e'(cfg_esz);
        x_eff          = (x_count == '0) ? CNT_MAX : x_count;
        y_eff          = (y_count == '0) ? CNT_MAX : y_count;
    end

    dma2d_stride_chk #(.MW(MW)) u_chk (
        .esz   (cfg.esz),
        .x_mod (x_mod),
        .legal (legal)
    );

    dma2d_step #(.AW(AW), .CW(CW), .MW(MW)) u_step (
        .two_d     (cfg.two_d),
        .cur_addr  (cur_addr),
        .cur_x     (cur_x),
        .cur_y     (cur_y),
        .x_reload  (x_eff),
        .x_mod     (x_mod),
        .y_mod     (y_mod),
        .nxt_addr  (nxt_addr),
        .nxt_x     (nxt_x),
        .nxt_y     (nxt_y),
        .row_end   (row_end),
        .last_elem (last_elem)
    );

    dma2d_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .reload_done (reload_done),
        .elem_ok     (elem_ok),
        .legal       (legal),
        .flow        (cfg.flow),
        .last_elem   (last_elem),
        .accept      (accept),
        .load        (load),
        .err_update  (err_update),
        .running     (running),
        .pending     (pending),
        .done        (done),
        .reload_req  (reload_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            cur_x    <= '0;
            cur_y    <= '0;
            row_irq  <= 1'b0;
            cfg_err  <= 1'b0;
        end else begin
            row_irq <= accept && row_end && cfg.row_irq_en;
            if (err_update) cfg_err <= !legal;
            if (load) begin
                cur_addr <= start_addr;
                cur_x    <= x_eff;
                cur_y    <= y_eff;
            end else if (accept) begin
                cur_addr <= nxt_addr;
                cur_x    <= nxt_x;
                cur_y    <= nxt_y;
            end
        end
    end

    assert_x_countdown_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && (cur_x > CW'(1))) |=> (cur_x == $past(cur_x) - CW'(1)));

    assert_irq_after_row_R3: assert property (@(posedge clk) disable iff (rst)
        row_irq |-> $past(running));

    assert_row_jump_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && row_end && !last_elem) |=>
        (cur_y == $past(cur_y) - CW'(1)));

    assert_wait_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (pending && !reload_done && !start) |=> $stable(cur_addr) && $stable(cur_x));

    assert_idle_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (!running && !start) |=> $stable(cur_addr) && $stable(cur_x));

    assert_err_halts_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !running);

endmodule

// File: tb/dma2d_seq_tb.sv
module dma2d_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, reload_done = 1'b0, elem_ok = 1'b0;
    logic        cfg_2d = 1'b0, cfg_row_irq = 1'b0;
    logic [1:0]  cfg_flow = 2'd0, cfg_esz = 2'd0;
    logic [31:0] start_addr = '0;
    logic [15:0] x_count = '0, x_mod = '0, y_count = '0, y_mod = '0;
    logic [31:0] cur_addr;
    logic [15:0] cur_x, cur_y;
    logic        row_irq, reload_req, running, done, cfg_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dma2d_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .reload_done(reload_done),
        .elem_ok(elem_ok), .cfg_2d(cfg_2d), .cfg_row_irq(cfg_row_irq),
        .cfg_flow(cfg_flow), .cfg_esz(cfg_esz), .start_addr(start_addr),
        .x_count(x_count), .x_mod(x_mod), .y_count(y_count), .y_mod(y_mod),
        .cur_addr(cur_addr), .cur_x(cur_x), .cur_y(cur_y), .row_irq(row_irq),
        .reload_req(reload_req), .running(running), .done(done), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [31:0] sa;
        logic [15:0] xc;
        logic [15:0] xm;
        logic [15:0] yc;
        logic [15:0] ym;
        logic        two_d;
        logic [1:0]  flow;
        logic [1:0]  esz;
        logic [7:0]  n;
        logic [31:0] ea;
        logic [15:0] ex;
        logic [15:0] ey;
        logic        er;
        logic        ed;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h1000, 16'd4, 16'd4,    16'd1, 16'd0,    1'b0, 2'd0, 2'd2, 8'd2, 32'h1008, 16'd2,    16'd1,    1'b1, 1'b0},
        '{32'h1000, 16'd4, 16'd4,    16'd1, 16'd0,    1'b0, 2'd0, 2'd2, 8'd4, 32'h1010, 16'd0,    16'd1,    1'b0, 1'b1},
        '{32'h2000, 16'd3, 16'hFFFE, 16'd1, 16'd0,    1'b0, 2'd0, 2'd1, 8'd2, 32'h1FFC, 16'd1,    16'd1,    1'b1, 1'b0},
        '{32'h0100, 16'd3, 16'd1,    16'd2, 16'd16,   1'b1, 2'd0, 2'd0, 8'd3, 32'h0112, 16'd3,    16'd1,    1'b1, 1'b0},
        '{32'h0100, 16'd3, 16'd1,    16'd2, 16'd16,   1'b1, 2'd0, 2'd0, 8'd6, 32'h0115, 16'd0,    16'd1,    1'b0, 1'b1},
        '{32'h0400, 16'd2, 16'd4,    16'd3, 16'hFFF0, 1'b1, 2'd0, 2'd2, 8'd4, 32'h03E8, 16'd2,    16'd1,    1'b1, 1'b0},
        '{32'h0000, 16'd0, 16'd1,    16'd0, 16'd0,    1'b0, 2'd0, 2'd0, 8'd1, 32'h0001, 16'hFFFE, 16'hFFFF, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic step(input int n);
        elem_ok = 1'b1;
        repeat (n) @(negedge clk);
        elem_ok = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 addr", cur_addr, 0);
        chk("R10 x", 32'(cur_x), 0);
        chk("R10 flags", {27'd0, row_irq, reload_req, running, done, cfg_err}, 0);

        // R1 R2 R4 R5 table walk
        for (int i = 0; i < NV; i++) begin
            start_addr = VECS[i].sa; x_count = VECS[i].xc; x_mod = VECS[i].xm;
            y_count = VECS[i].yc; y_mod = VECS[i].ym; cfg_2d = VECS[i].two_d;
            cfg_flow = VECS[i].flow; cfg_esz = VECS[i].esz; cfg_row_irq = 1'b0;
            do_start();
            chk("R1 start addr", cur_addr, VECS[i].sa);
            chk("R1 running", 32'(running), 1);
            step(int'(VECS[i].n));
            chk("R2/R4/R5 addr", cur_addr, VECS[i].ea);
            chk("R2/R4/R5 x", 32'(cur_x), 32'(VECS[i].ex));
            chk("R4 y", 32'(cur_y), 32'(VECS[i].ey));
            chk("R5 run/done", {30'd0, running, done}, {30'd0, VECS[i].er, VECS[i].ed});
        end

        // R3 R6 R7: row interrupt, reload request, wait, reload
        cfg_2d = 1'b0; cfg_row_irq = 1'b1; cfg_flow = 2'd1; cfg_esz = 2'd0;
        start_addr = 32'h50; x_count = 16'd2; x_mod = 16'd1; y_count = 16'd1;
        do_start();
        step(1);
        chk("R3 no irq mid-row", 32'(row_irq), 0);
        step(1);
        chk("R3 irq pulse", 32'(row_irq), 1);
        chk("R6 reload_req", 32'(reload_req), 1);
        chk("R6 still running", 32'(running), 1);
        chk("R6 addr", cur_addr, 32'h52);
        @(negedge clk);
        chk("R3 irq one cycle", 32'(row_irq), 0);
        chk("R6 req one cycle", 32'(reload_req), 0);
        step(3);
        chk("R7 wait ignores addr", cur_addr, 32'h52);
        chk("R7 wait ignores x", 32'(cur_x), 0);
        start_addr = 32'h80; x_count = 16'd5;
        reload_done = 1'b1;
        @(negedge clk);
        reload_done = 1'b0;
        chk("R7 reload addr", cur_addr, 32'h80);
        chk("R7 reload x", 32'(cur_x), 5);
        step(1);
        chk("R7 resumes", cur_addr, 32'h81);

        // R3 disabled irq, R5 stop, R8 idle ignores strobes
        cfg_row_irq = 1'b0; cfg_flow = 2'd0; start_addr = 32'h0; x_count = 16'd1;
        do_start();
        step(1);
        chk("R3 irq disabled", 32'(row_irq), 0);
        chk("R5 done", 32'(done), 1);
        step(2);
        chk("R8 idle addr", cur_addr, 32'h1);
        chk("R8 idle x", 32'(cur_x), 0);

        // R9 stride checks
        cfg_esz = 2'd2; x_mod = 16'd2; start_addr = 32'h900;
        do_start();
        chk("R9 bad stride err", 32'(cfg_err), 1);
        chk("R9 not running", 32'(running), 0);
        step(1);
        chk("R9 addr unchanged", cur_addr, 32'h1);
        cfg_esz = 2'd3; x_mod = 16'd1;
        do_start();
        chk("R9 reserved size err", 32'(cfg_err), 1);
        cfg_esz = 2'd2; x_mod = 16'hFFFC; x_count = 16'd3;
        do_start();
        chk("R9 legal clears err", 32'(cfg_err), 0);
        step(1);
        chk("R2 negative stride", cur_addr, 32'h8FC);

        // R1 start beats strobe in same cycle
        start = 1'b1; elem_ok = 1'b1;
        @(negedge clk);
        start = 1'b0; elem_ok = 1'b0;
        chk("R1 start priority", cur_addr, 32'h900);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule